// File: doc/BRIEF.md
# Multichannel DAC Serial Write Controller

This block sits on the host side of a serial link to a multichannel digital-to-analog converter. It accepts a 24-bit command word through a valid/ready port, frames it with an active-low frame-select line (`sync_n`) and clocks it out most significant bit first on `din`. The serial clock idles high, and the converter samples `din` on each falling edge. Every timing minimum of the link is a parameter counted in system clock cycles: the clock phases, the frame-select setup and hold, the gap between frames, the BUSY wait and the commit pulse width.

After a write frame, the controller waits for the converter's active-low BUSY line to return high. It then drives an active-low commit strobe (`ldac_n`) for a set number of cycles, which moves the new value to the analog output. If a hold-commit flag is set with the command, the strobe is skipped, so several channel writes can be staged and committed together later. If BUSY stays low too long, the controller raises an error flag and abandons the commit. A readback frame captures the converter's serial output on each falling edge and presents the 24 captured bits as a word. It waits for no BUSY and drives no commit strobe, and the frame-select gap after it is stretched.

Top module: `dac_serial_writer`

## Requirements
- R1: Each frame has exactly 24 falling edges of `sclk` while `sync_n` is low. The first falling edge comes SYNC_SETUP cycles after `sync_n` falls. `sync_n` rises SCLK_LO+SYNC_HOLD cycles after the 24th falling edge.
- R2: The 24-bit word is sent most significant bit first. `din` changes only while `sclk` is high, so the bit sampled at the k-th falling edge is bit 24-k of the word.
- R3: `sclk` idles high. Inside a frame, each low phase lasts SCLK_LO cycles and each high phase between falling edges lasts SCLK_HI cycles.
- R4: Between frames, `sync_n` stays high for at least GAP_WR cycles after a write frame and at least GAP_RB cycles after a readback frame.
- R5: In a readback frame, `sdo` is captured at every falling edge, MSB first. When `sync_n` rises, `rd_word` holds the 24 captured bits and `rd_valid` pulses for one cycle. Write frames never pulse `rd_valid`.
- R6: After a write frame without hold-commit, the controller waits BUSY_WAIT cycles, then waits for `busy_n` to be high. It then drives `ldac_n` low for exactly LDAC_W cycles, once.
- R7: `ldac_n` never goes low while `busy_n` is low or while `sync_n` is low.
- R8: If `busy_n` is sampled low for BUSY_TMO consecutive cycles after a write frame, `busy_err` is set, no commit pulse follows, and the controller returns to idle. `busy_err` clears when the next command is accepted.
- R9: A write frame with `cmd_hold` set produces no `ldac_n` pulse.
- R10: `cmd_ready` is low from the acceptance of a command until the frame, the BUSY wait and any commit pulse are complete, and it is never high while `sync_n` or `ldac_n` is low.
- R11: Out of reset, `sync_n`, `sclk` and `ldac_n` are high, `cmd_ready` is high, and `busy_err` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_word | input | 24 | Word to shift out |
| cmd_rb | input | 1 | Frame is a readback frame |
| cmd_hold | input | 1 | Skip the commit pulse after this write |
| busy_n | input | 1 | Converter busy, active low |
| sdo | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles high |
| sync_n | output | 1 | Frame select, active low |
| din | output | 1 | Serial data to the converter |
| ldac_n | output | 1 | Commit strobe, active low |
| rd_word | output | 24 | Last captured readback word |
| rd_valid | output | 1 | One-cycle pulse when `rd_word` is updated |
| busy_err | output | 1 | BUSY stayed low past the limit |

## Verification
Some properties are checked on every cycle by the embedded assertions. No `sclk` edge occurs outside a frame, `din` stays still through every low clock phase, the commit strobe never falls during a frame or while BUSY is low, `cmd_ready` is never high during a frame or a commit pulse, and the error flag rises only after BUSY was seen low. The remaining behaviour can only be shown by the bench's sweeps: the exact count of 24 falling edges, the bit order, the phase lengths, the inter-frame gaps after each frame type, the readback word, and whether a commit pulse or timeout occurs for each combination of readback, hold-commit and BUSY duration.

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int WORD_W     = 24,
  parameter int SCLK_HI    = 1,
  parameter int SCLK_LO    = 1,
  parameter int SYNC_SETUP = 1,
  parameter int SYNC_HOLD  = 1,
  parameter int GAP_WR     = 1,
  parameter int GAP_RB     = 14,
  parameter int BUSY_WAIT  = 3,
  parameter int LDAC_W     = 1,
  parameter int BUSY_TMO   = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_rb,
  input  logic              cmd_hold,
  input  logic              busy_n,
  input  logic              sdo,
  output logic              sclk,
  output logic              sync_n,
  output logic              din,
  output logic              ldac_n,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              busy_err
);

  localparam int BW = $clog2(WORD_W);
  localparam int TW = 16;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL, S_BWAIT, S_BUSY, S_LDAC} st_t;

  st_t              st;
  logic [TW-1:0]    tmr, gap;
  logic [BW-1:0]    bi;
  logic [WORD_W-1:0] sh, rsh;
  logic             rb_q, hold_q;

  assign cmd_ready = (st == S_IDLE) && (gap == '0);
  wire take = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      gap      <= '0;
      bi       <= '0;
      sh       <= '0;
      rsh      <= '0;
      rb_q     <= 1'b0;
      hold_q   <= 1'b0;
      sclk     <= 1'b1;
      sync_n   <= 1'b1;
      din      <= 1'b0;
      ldac_n   <= 1'b1;
      rd_word  <= '0;
      rd_valid <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (gap != '0) gap <= gap - 1'b1;
      case (st)
        S_IDLE: if (take) begin
          sh       <= cmd_word;
          din      <= cmd_word[WORD_W-1];
          rb_q     <= cmd_rb;
          hold_q   <= cmd_hold;
          sync_n   <= 1'b0;
          busy_err <= 1'b0;
          tmr      <= TW'(SYNC_SETUP - 1);
          st       <= S_LEAD;
        end
        S_LEAD: if (tmr == '0) begin
          sclk <= 1'b0;
          rsh  <= {rsh[WORD_W-2:0], sdo};
          bi   <= BW'(WORD_W - 1);
          tmr  <= TW'(SCLK_LO - 1);
          st   <= S_SHIFT;
        end else tmr <= tmr - 1'b1;
        S_SHIFT: if (tmr != '0) tmr <= tmr - 1'b1;
        else if (!sclk) begin
          sclk <= 1'b1;
          if (bi == '0) begin
            tmr <= TW'(SYNC_HOLD - 1);
            st  <= S_TAIL;
          end else begin
            bi  <= bi - 1'b1;
            din <= sh[WORD_W-2];
            sh  <= {sh[WORD_W-2:0], 1'b0};
            tmr <= TW'(SCLK_HI - 1);
          end
        end else begin
          sclk <= 1'b0;
          rsh  <= {rsh[WORD_W-2:0], sdo};
          tmr  <= TW'(SCLK_LO - 1);
        end
        S_TAIL: if (tmr == '0) begin
          sync_n <= 1'b1;
          din    <= 1'b0;
          gap    <= TW'((rb_q ? GAP_RB : GAP_WR) - 1);
          if (rb_q) begin
            rd_word  <= rsh;
            rd_valid <= 1'b1;
            st       <= S_IDLE;
          end else begin
            tmr <= TW'(BUSY_WAIT - 1);
            st  <= S_BWAIT;
          end
        end else tmr <= tmr - 1'b1;
        S_BWAIT: if (tmr == '0) st <= S_BUSY;
        else tmr <= tmr - 1'b1;
        S_BUSY: if (busy_n) begin
          if (hold_q) st <= S_IDLE;
          else begin
            ldac_n <= 1'b0;
            tmr    <= TW'(LDAC_W - 1);
            st     <= S_LDAC;
          end
        end else if (tmr == TW'(BUSY_TMO - 1)) begin
          busy_err <= 1'b1;
          st       <= S_IDLE;
        end else tmr <= tmr + 1'b1;
        S_LDAC: if (tmr == '0) begin
          ldac_n <= 1'b1;
          st     <= S_IDLE;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sclk_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !sync_n);
  assert_din_still_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(!sclk)) |-> $stable(din));
  assert_ldac_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldac_n) |-> ($past(busy_n) && sync_n));
  assert_ldac_not_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n |-> sync_n);
  assert_err_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_err) |-> !$past(busy_n));
  assert_ready_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n || !ldac_n) |-> !cmd_ready);

endmodule

// File: tb/dac_serial_writer_tb_top.sv
module dac_serial_writer_tb_top;
  localparam int SCLK_HI = 1, SCLK_LO = 1, SYNC_SETUP = 1, SYNC_HOLD = 1;
  localparam int GAP_WR = 1, GAP_RB = 14, LDAC_W = 1, BUSY_TMO = 63;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_rb = 0, cmd_hold = 0, busy_n = 1, sdo = 0;
  logic [23:0] cmd_word = '0;
  logic cmd_ready, sclk, sync_n, din, ldac_n, rd_valid, busy_err;
  logic [23:0] rd_word;

  always #10 clk = ~clk;

  dac_serial_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_rb(cmd_rb), .cmd_hold(cmd_hold), .busy_n(busy_n),
    .sdo(sdo), .sclk(sclk), .sync_n(sync_n), .din(din), .ldac_n(ldac_n),
    .rd_word(rd_word), .rd_valid(rd_valid), .busy_err(busy_err));

  int total = 0, bad = 0;
  int cur_blen = 0;
  logic cur_rb = 0;
  logic [23:0] resp = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: BUSY pulse after write frames, SDO shifted on rising edges
  logic mp_sync = 1, ms_sync = 1, ms_sclk = 1, pend = 0;
  int bleft = 0, sidx = 0;
  always @(negedge clk) begin
    if (pend) begin
      pend = 0;
      if (cur_blen > 0) begin busy_n = 0; bleft = cur_blen; end
    end else if (!busy_n) begin
      bleft--;
      if (bleft == 0) busy_n = 1;
    end
    if (!mp_sync && sync_n && !cur_rb) pend = 1;
    mp_sync = sync_n;
    if (ms_sync && !sync_n) begin sdo = resp[23]; sidx = 22; end
    else if (!sync_n && sclk && !ms_sclk && sidx >= 0) begin sdo = resp[sidx]; sidx--; end
    ms_sync = sync_n;
    ms_sclk = sclk;
  end

  // monitor
  int cyc = 0, falls = 0, setup_len = 0, tail_len = 0, gap_meas = 0, run = 0;
  int sync_fall_cyc = 0, last_fall_cyc = 0, last_rise_cyc = 0;
  int ldac_pulses = 0, lw = 0, rdv_cnt = 0;
  bit phase_bad = 0, ldac_bad = 0, ready_bad = 0;
  logic [23:0] word_cap = '0, rd_cap = '0;
  logic p_sync = 1, p_sclk = 1, p_ldac = 1;
  always @(negedge clk) begin
    cyc++;
    if (p_sync && !sync_n) begin
      gap_meas = cyc - last_rise_cyc; sync_fall_cyc = cyc;
      falls = 0; word_cap = '0; phase_bad = 0; ldac_pulses = 0; lw = 0;
      ldac_bad = 0; ready_bad = 0; rdv_cnt = 0;
    end
    if (!p_sync && sync_n) begin last_rise_cyc = cyc; tail_len = cyc - last_fall_cyc; end
    if (sclk != p_sclk) begin
      if (!sclk) begin
        if (!sync_n) begin
          if (falls == 0) setup_len = cyc - sync_fall_cyc;
          else if (run != SCLK_HI) phase_bad = 1;
          falls++;
          word_cap = {word_cap[22:0], din};
          last_fall_cyc = cyc;
        end else phase_bad = 1;
      end else if (run != SCLK_LO) phase_bad = 1;
      run = 1;
    end else run++;
    if (p_ldac && !ldac_n) begin
      ldac_pulses++; lw = 1;
      if (!busy_n || !sync_n) ldac_bad = 1;
    end else if (!ldac_n) lw++;
    if (rd_valid) begin rdv_cnt++; rd_cap = rd_word; end
    if (cmd_ready && (!sync_n || !ldac_n)) ready_bad = 1;
    p_sync = sync_n; p_sclk = sclk; p_ldac = ldac_n;
  end

  bit first = 1;
  logic prev_rb = 0;
  task automatic run_txn(input logic [23:0] w, input logic rb, input logic hold, input int blen);
    bit ldac_exp, err_exp;
    ldac_exp = !rb && !hold && (blen < BUSY_TMO);
    err_exp  = !rb && (blen >= BUSY_TMO);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cur_blen = blen; cur_rb = rb; resp = w ^ 24'h5A3C0F;
    cmd_word = w; cmd_rb = rb; cmd_hold = hold; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    #1;
    check(falls == 24, "R1 fall count", falls, 24);
    check(setup_len == SYNC_SETUP, "R1 sync setup", setup_len, SYNC_SETUP);
    check(tail_len == SCLK_LO + SYNC_HOLD, "R1 sync hold", tail_len, SCLK_LO + SYNC_HOLD);
    check(word_cap == w, "R2 shifted word", word_cap, w);
    check(!phase_bad, "R3 clock phases", phase_bad, 0);
    if (!first)
      check(gap_meas >= (prev_rb ? GAP_RB : GAP_WR), "R4 frame gap", gap_meas, prev_rb ? GAP_RB : GAP_WR);
    if (rb) begin
      check(rdv_cnt == 1, "R5 rd_valid pulse", rdv_cnt, 1);
      check(rd_cap == resp, "R5 readback word", rd_cap, resp);
    end else check(rdv_cnt == 0, "R5 no rd_valid on write", rdv_cnt, 0);
    check(ldac_pulses == int'(ldac_exp), "R6 commit pulses", ldac_pulses, ldac_exp);
    if (ldac_exp) check(lw == LDAC_W, "R6 commit width", lw, LDAC_W);
    check(!ldac_bad, "R7 commit while busy or framed", ldac_bad, 0);
    check(busy_err == err_exp, "R8 busy timeout flag", busy_err, err_exp);
    if (hold) check(ldac_pulses == 0, "R9 hold skips commit", ldac_pulses, 0);
    check(!ready_bad, "R10 ready during frame", ready_bad, 0);
    first = 0; prev_rb = rb;
    while (!busy_n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(sync_n && sclk && ldac_n, "R11 idle lines", {sync_n, sclk, ldac_n}, 3'b111);
    check(cmd_ready, "R11 ready", cmd_ready, 1);
    check(!busy_err && !rd_valid, "R11 flags", {busy_err, rd_valid}, 0);
    for (int i = 0; i < 24; i++)
      run_txn(24'(1) << i, (i % 3) == 0, i[0], 0);
    for (int b = 0; b < 4; b++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          run_txn(24'(32'h9E3779B9 * (w + 7 * b + 3 * m + 1)) ^ {24{w[0]}},
                  m[0], m[1], (b == 0) ? 0 : (b == 1) ? 4 : (b == 2) ? 30 : 120);
    run_txn(24'hFFFFFF, 1, 0, 0);
    run_txn(24'h000000, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule